// File: doc/BRIEF.md
# Four-Element Configurable Logic Cluster

This block is one logic tile of a programmable fabric. It holds four identical logic elements. Each element evaluates an arbitrary four-input Boolean function through a 16-entry lookup table. It can either pass that result straight out or hold it in a flip-flop and present the registered copy. The function bits, the input routing and the output mode of all four elements come from a flat parallel configuration bus. External configuration storage holds that bus steady.

Each of the sixteen element inputs has its own selector inside the cluster. A selector can pick any of the 16 cluster inputs or any of the 4 element outputs. Elements can therefore be chained, or fed back on themselves through their flip-flops, without leaving the tile. The four element outputs are the cluster outputs. A loop that passes only through unregistered outputs is treated as a configuration error and is never loaded.

Top module: `clb_cluster`

## Requirements
- R1: Each element occupies a 37-bit slice of `cfgBits` starting at bit 37*e. Slice bits [15:0] are the table contents. Bits [16+5k+4:16+5k] are the selector code for element input k (k = 0..3). Bit 36 is the output mode. When the output mode is 0, the element output equals table bit i, where i = {in3,in2,in1,in0}, in the same cycle.
- R2: Selector codes 0 to 15 route cluster input `clusterIn[code]` to the element input.
- R3: Selector codes 16 to 19 route element outputs 0 to 3 (`clusterOut[code-16]`) to the element input, so elements chain inside the cluster.
- R4: Selector codes 20 to 31 drive a constant 0 into the element input, whatever the cluster inputs are.
- R5: When the output mode is 1, the element output is the table result captured at the previous rising clock edge. A change of inputs between edges does not reach the output until the next edge.
- R6: While `rst` is high at a rising edge, every flip-flop clears to 0. A registered-mode output therefore reads 0 in the cycle after.
- R7: A registered output fed back to its own element, or to another element, forms sequential logic such as a toggle or a counter. Its state advances once per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all element flip-flops |
| rst | input | 1 | Active-high synchronous clear of the flip-flops |
| cfgBits | input | 148 | Flat configuration, four 37-bit element slices |
| clusterIn | input | 16 | External inputs of the cluster |
| clusterOut | output | 4 | Element outputs, bit e from element e |

## Verification
A wrong table bit or a wrong selector in combinational mode appears on `clusterOut` in the same cycle as the input pattern that reaches it. Sweeping several patterns per configuration exposes it at once. A flip-flop that does not clear, or that captures the wrong value, shows on a registered output one edge later. In a feedback toggle or counter, the error then keeps propagating, so it stays visible on every following cycle.

// File: rtl/clb_pkg.sv
package clb_pkg;
  parameter int N_ELEM = 4;
  parameter int N_IN = 16;
  parameter int K = 4;
  localparam int LUT_SIZE = 2 ** K;
  localparam int SRC_COUNT = N_IN + N_ELEM;
  localparam int SEL_W = $clog2(SRC_COUNT);
  localparam int SRC_PAD = 2 ** SEL_W;
  localparam int ELEM_W = 1 + K * SEL_W + LUT_SIZE;
  localparam int CFG_W = N_ELEM * ELEM_W;

  typedef struct packed {
    logic useReg;
    logic [K*SEL_W-1:0] sel;
    logic [LUT_SIZE-1:0] lut;
  } elemCfg_t;
endpackage

// File: rtl/clb_cfg_decode.sv
module clb_cfg_decode
  import clb_pkg::*;
(
  input  logic [CFG_W-1:0] cfgBits,
  output elemCfg_t         cfgVec [N_ELEM]
);
  for (genvar e = 0; e < N_ELEM; e++) begin : g_slice
    assign cfgVec[e] = elemCfg_t'(cfgBits[e*ELEM_W +: ELEM_W]);
  end
endmodule

// File: rtl/clb_element.sv
module clb_element
  import clb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [LUT_SIZE-1:0] lutBits,
  input  logic [K-1:0]        inBits,
  input  logic                useReg,
  output logic                lutOut,
  output logic                elemOut
);
  logic ffQ;

  assign lutOut = lutBits[inBits];

  always_ff @(posedge clk) begin
    if (rst) ffQ <= 1'b0;
    else     ffQ <= lutOut;
  end

  assign elemOut = useReg ? ffQ : lutOut;
endmodule

// File: rtl/clb_datapath.sv
module clb_datapath
  import clb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  elemCfg_t          cfgVec [N_ELEM],
  input  logic [N_IN-1:0]   clusterIn,
  output logic [N_ELEM-1:0] elemOut,
  output logic [N_ELEM-1:0] lutVec
);
  logic [SRC_PAD-1:0] srcPad;

  assign srcPad = {{(SRC_PAD-SRC_COUNT){1'b0}}, elemOut, clusterIn};

  for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
    logic [K-1:0] pick;
    for (genvar j = 0; j < K; j++) begin : g_pin
      assign pick[j] = srcPad[cfgVec[e].sel[j*SEL_W +: SEL_W]];
    end
    clb_element u_elem (
      .clk    (clk),
      .rst    (rst),
      .lutBits(cfgVec[e].lut),
      .inBits (pick),
      .useReg (cfgVec[e].useReg),
      .lutOut (lutVec[e]),
      .elemOut(elemOut[e])
    );
  end
endmodule

// File: rtl/clb_cluster.sv
module clb_cluster
  import clb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfgBits,
  input  logic [N_IN-1:0]   clusterIn,
  output logic [N_ELEM-1:0] clusterOut
);
  elemCfg_t          cfgVec [N_ELEM];
  logic [N_ELEM-1:0] lutVec;

  clb_cfg_decode u_ctl (
    .cfgBits(cfgBits),
    .cfgVec (cfgVec)
  );

  clb_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .cfgVec   (cfgVec),
    .clusterIn(clusterIn),
    .elemOut  (clusterOut),
    .lutVec   (lutVec)
  );
endmodule

// File: rtl/clb_cluster_chk.sv
module clb_cluster_chk
  import clb_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [CFG_W-1:0]  cfgBits,
  input logic [N_IN-1:0]   clusterIn,
  input logic [N_ELEM-1:0] clusterOut,
  input logic [N_ELEM-1:0] lutVec
);
  for (genvar e = 0; e < N_ELEM; e++) begin : g_chk
    logic [ELEM_W-1:0]   slice;
    logic [LUT_SIZE-1:0] tbl;
    logic                regMode;
    logic                allExt;
    logic                allZero;
    logic [K-1:0]        extIdx;

    always_comb begin
      slice   = cfgBits[e*ELEM_W +: ELEM_W];
      tbl     = slice[LUT_SIZE-1:0];
      regMode = slice[ELEM_W-1];
      allExt  = 1'b1;
      allZero = 1'b1;
      extIdx  = '0;
      for (int j = 0; j < K; j++) begin
        logic [SEL_W-1:0] code;
        code = slice[LUT_SIZE + j*SEL_W +: SEL_W];
        if (int'(code) >= N_IN) allExt = 1'b0;
        else extIdx[j] = clusterIn[code[$clog2(N_IN)-1:0]];
        if (int'(code) < SRC_COUNT) allZero = 1'b0;
      end
    end

    // R1 and R2: table lookup addressed by routed external inputs
    a_r2_ext_lookup: assert property (@(posedge clk) disable iff (rst)
      allExt |-> lutVec[e] == tbl[extIdx]);

    // R4: out-of-range codes address table entry 0
    a_r4_const_zero: assert property (@(posedge clk) disable iff (rst)
      allZero |-> lutVec[e] == tbl[0]);

    // R5: registered output shows the previous table result
    a_r5_reg_delay: assert property (@(posedge clk) disable iff (rst)
      (regMode && $stable(regMode) && !$past(rst)) |-> clusterOut[e] == $past(lutVec[e]));

    // R6: reset clears the registered output
    a_r6_reset_clear: assert property (@(posedge clk) disable iff (rst)
      (regMode && $past(rst)) |-> clusterOut[e] == 1'b0);
  end
endmodule

bind clb_cluster clb_cluster_chk u_chk (.*);

// File: tb/clb_cluster_test.sv
module clb_cluster_test;
  localparam int CLK_PERIOD = 10;
  localparam int EW = 37;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [147:0] cfgBits = '0;
  logic [15:0]  clusterIn = '0;
  logic [3:0]   clusterOut;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  clb_cluster uut (
    .clk(clk), .rst(rst), .cfgBits(cfgBits),
    .clusterIn(clusterIn), .clusterOut(clusterOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [EW-1:0] mkElem(logic [15:0] lut, logic [4:0] s0, logic [4:0] s1,
                                           logic [4:0] s2, logic [4:0] s3, logic regMode);
    return {regMode, s3, s2, s1, s0, lut};
  endfunction

  function automatic logic [EW-1:0] idleElem();
    return mkElem(16'h0000, 5'd31, 5'd31, 5'd31, 5'd31, 1'b0);
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s got=%h exp=%h", req, act, exp);
    end
  endtask

  // R6: reset state with registered outputs whose tables are all ones
  task automatic testReset();
    logic [EW-1:0] el;
    el = mkElem(16'hFFFF, 5'd31, 5'd31, 5'd31, 5'd31, 1'b1);
    cfgBits = {el, el, el, el};
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R6 reset clears", clusterOut, 4'h0);
    rst = 1'b0;
    #1;
    check("R6 held until edge", clusterOut, 4'h0);
    @(posedge clk); @(negedge clk);
    check("R5 first capture", clusterOut, 4'hF);
  endtask

  // R1 R2: combinational functions over external inputs
  task automatic testExternal();
    logic [15:0] pats [6];
    pats[0] = 16'h0000; pats[1] = 16'h000F; pats[2] = 16'hF00F;
    pats[3] = 16'h0420; pats[4] = 16'hA5A5; pats[5] = 16'hFFFF;
    @(negedge clk);
    cfgBits = {mkElem(16'hFF00, 5'd31, 5'd31, 5'd31, 5'd10, 1'b0),
               mkElem(16'hAAAA, 5'd5, 5'd31, 5'd31, 5'd31, 1'b0),
               mkElem(16'h6996, 5'd15, 5'd14, 5'd13, 5'd12, 1'b0),
               mkElem(16'h8000, 5'd0, 5'd1, 5'd2, 5'd3, 1'b0)};
    for (int p = 0; p < 6; p++) begin
      logic [3:0] exp;
      clusterIn = pats[p];
      #1;
      exp[0] = &pats[p][3:0];
      exp[1] = ^pats[p][15:12];
      exp[2] = pats[p][5];
      exp[3] = pats[p][10];
      check("R1 R2 external lookup", clusterOut, exp);
      @(negedge clk);
    end
  endtask

  // R4: unused selector codes give constant 0
  task automatic testConstZero();
    @(negedge clk);
    cfgBits = {idleElem(), idleElem(),
               mkElem(16'hFFFE, 5'd25, 5'd21, 5'd30, 5'd20, 1'b0),
               mkElem(16'h0001, 5'd20, 5'd24, 5'd28, 5'd31, 1'b0)};
    for (int p = 0; p < 3; p++) begin
      clusterIn = (p == 0) ? 16'h0000 : (p == 1) ? 16'hFFFF : 16'h3C5A;
      #1;
      check("R4 constant zero", clusterOut, 4'b0001);
      @(negedge clk);
    end
  endtask

  // R3: chain e0 -> e1 -> e2 -> e3 inside the cluster
  task automatic testChain();
    @(negedge clk);
    cfgBits = {mkElem(16'hAAAA, 5'd18, 5'd31, 5'd31, 5'd31, 1'b0),
               mkElem(16'h6666, 5'd17, 5'd2, 5'd31, 5'd31, 1'b0),
               mkElem(16'h5555, 5'd16, 5'd31, 5'd31, 5'd31, 1'b0),
               mkElem(16'h8888, 5'd0, 5'd1, 5'd31, 5'd31, 1'b0)};
    for (int p = 0; p < 8; p++) begin
      logic [3:0] exp;
      clusterIn = {13'h0, p[2:0]};
      #1;
      exp[0] = p[0] & p[1];
      exp[1] = ~exp[0];
      exp[2] = exp[1] ^ p[2];
      exp[3] = exp[2];
      check("R3 chained feedback", clusterOut, exp);
      @(negedge clk);
    end
  endtask

  // R5: registered output lags by one edge
  task automatic testRegistered();
    logic [3:0] seq;
    seq = 4'b1101;
    @(negedge clk);
    cfgBits = {idleElem(), idleElem(), idleElem(),
               mkElem(16'hAAAA, 5'd7, 5'd31, 5'd31, 5'd31, 1'b1)};
    clusterIn = '0;
    @(posedge clk); @(negedge clk);
    check("R5 settled low", clusterOut, 4'h0);
    for (int i = 0; i < 4; i++) begin
      logic prev;
      prev = clusterOut[0];
      clusterIn[7] = seq[i];
      #1;
      check("R5 holds between edges", clusterOut, {3'b0, prev});
      @(posedge clk); @(negedge clk);
      check("R5 captured at edge", clusterOut, {3'b0, seq[i]});
    end
  endtask

  // R7 R6: toggle and two-bit counter from registered feedback
  task automatic testCounter();
    logic q0, q1, n0, n1;
    @(negedge clk);
    cfgBits = {idleElem(), idleElem(),
               mkElem(16'h6666, 5'd16, 5'd17, 5'd31, 5'd31, 1'b1),
               mkElem(16'h5555, 5'd16, 5'd31, 5'd31, 5'd31, 1'b1)};
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R6 counter cleared", clusterOut, 4'h0);
    rst = 1'b0;
    q0 = 1'b0; q1 = 1'b0;
    for (int i = 0; i < 7; i++) begin
      @(posedge clk); @(negedge clk);
      n0 = ~q0; n1 = q1 ^ q0;
      q0 = n0; q1 = n1;
      check("R7 feedback counter", clusterOut, {2'b00, q1, q0});
    end
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R6 mid-run reset", clusterOut, 4'h0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R7 restart after reset", clusterOut, 4'b0001);
  endtask

  initial begin
    testReset();
    testExternal();
    testConstZero();
    testChain();
    testRegistered();
    testCounter();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule